// File: doc/BRIEF.md
# Selectable-Interval Watch Timer Controller

This block counts cycles of a slow auxiliary time base and raises an interrupt at a power-of-two interval that software selects. The counter is free-running and wraps. It advances only on cycles where the time-base enable input is high. A 4-bit interval code picks one of sixteen counter taps, so the period runs from 2^8 to 2^23 counted cycles. At a 2 MHz time base that spans about 128 µs to 4.2 s. At 100 kHz it spans about 2.5 ms to 84 s.

Software uses one 8-bit control/status register on a simple synchronous bus. A write takes effect at the clock edge where the write enable is high. Read data is a plain function of the stored state. The register holds:

- the interval code;
- a counter-clear strobe, which software writes as zero and which always reads back as one;
- a sticky interval flag, which software can clear but never set;
- an interrupt enable.

The interrupt request is high while both the flag and the enable are set.

Top module: `watch_timer`

## Requirements
- R1: After reset, the register reads 0x10 and the interrupt request is low. In that value the interval code (bits 3:0), the flag (bit 5) and the enable (bit 6) are all 0, and bit 4 reads 1.
- R2: With interval code c in bits 3:0, starting from a counter value of zero, the flag (bit 5) stays 0 for the first 2^(8+c)-1 enabled counts. It becomes 1 at the edge of count number 2^(8+c). This happens once per 2^(8+c) counts.
- R3: The counter advances only at edges where the time-base enable is high. While the enable is low the counter holds its value, for any number of cycles.
- R4: Writing 0 to bit 4 clears the counter to zero at that edge, even if the time-base enable is high in the same cycle. Writing 1 to bit 4 leaves the counter unchanged. Bit 4 always reads 1.
- R5: Once set, the flag stays set until a write puts 0 in bit 5. Writing 1 to bit 5 leaves the flag unchanged.
- R6: When an interval elapses in the same cycle as a write that clears the flag, the flag ends up set.
- R7: The interrupt request is high exactly while the enable (bit 6) and the flag are both 1.
- R8: Writing a new interval code does not reset the counter. The next flag comes when the running count crosses the next multiple of the new period.
- R9: Bit 7 always reads 0, and writing 1 to it has no effect on any other field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for the bus and the counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Time-base enable; the counter advances on cycles where it is high |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data |
| irqReq | output | 1 | Interval interrupt request |

## Verification
The counter is hidden, so a wrong internal count shows up only as a flag that rises one or more counted cycles early or late. The bench therefore samples the flag one count before the expected edge and again at the edge itself. A counter that ignores the clear strobe or the time-base enable, or that resets when the code changes, moves the flag by hundreds of counts. That error is seen at the first interval boundary after the bad event. A wrong flag-set versus flag-clear priority, or wrong irq gating, shows in the read-back and the interrupt pin in the cycle right after the write.

// File: rtl/wt_pkg.sv
package wt_pkg;
  // Interval code width and the register bit map that software decodes.
  localparam int SEL_W     = 4;
  localparam int REG_W     = 8;
  localparam int CLR_BIT   = 4;
  localparam int FLAG_BIT  = 5;
  localparam int EN_BIT    = 6;
  localparam int RSVD_BIT  = 7;

  // Strobes from the control side to the datapath.
  typedef struct packed {
    logic             cntClear;
    logic [SEL_W-1:0] tapSel;
  } wtStrobes_t;
endpackage

// File: rtl/wt_datapath.sv
module wt_datapath
  import wt_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int BASE_EXP = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tickEn,
  input  wtStrobes_t strobes,
  output logic       intervalEvt
);
  localparam int NUM_TAPS = 1 << SEL_W;
  localparam int TOP_TAP  = BASE_EXP - 1 + NUM_TAPS - 1;

  logic [CNT_W-1:0]    cnt;
  logic [NUM_TAPS-1:0] tapWrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (strobes.cntClear) cnt <= '0;
    else if (tickEn)           cnt <= cnt + 1'b1;
  end

  // Tap g falls on the next count exactly when bits [BASE_EXP-1+g:0] are all ones.
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign tapWrap[g] = &cnt[BASE_EXP-1+g:0];
  end

  assign intervalEvt = tickEn && !strobes.cntClear && tapWrap[strobes.tapSel];

  initial begin
    assert (CNT_W > TOP_TAP) else $error("counter too narrow for the top tap");
  end

  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.cntClear |=> (cnt == '0));

  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tickEn && !strobes.cntClear) |=> $stable(cnt));

  assert_advance_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tickEn && !strobes.cntClear) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/wt_control.sv
module wt_control
  import wt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             intervalEvt,
  output wtStrobes_t       strobes,
  output logic [REG_W-1:0] rdData,
  output logic             irqReq
);
  logic [SEL_W-1:0] selQ;
  logic             flagQ;
  logic             enQ;
  logic             flagClrReq;
  logic             unusedRsvd;

  assign flagClrReq = wrEn && !wrData[FLAG_BIT];
  assign unusedRsvd = wrData[RSVD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selQ <= '0;
      enQ  <= 1'b0;
    end else if (wrEn) begin
      selQ <= wrData[SEL_W-1:0];
      enQ  <= wrData[EN_BIT];
    end
  end

  // Set by an elapsed interval wins over a software clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           flagQ <= 1'b0;
    else if (intervalEvt) flagQ <= 1'b1;
    else if (flagClrReq)  flagQ <= 1'b0;
  end

  always_comb begin
    strobes.cntClear = wrEn && !wrData[CLR_BIT];
    strobes.tapSel   = selQ;
  end

  always_comb begin
    rdData              = '0;
    rdData[SEL_W-1:0]   = selQ;
    rdData[CLR_BIT]     = 1'b1;
    rdData[FLAG_BIT]    = flagQ;
    rdData[EN_BIT]      = enQ;
  end

  assign irqReq = enQ && flagQ;

  assert_flag_rise_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flagQ) |-> $past(intervalEvt));

  assert_flag_fall_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flagQ) |-> $past(wrEn && !wrData[FLAG_BIT]));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    intervalEvt |=> flagQ);

  assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> (rdData[EN_BIT] && rdData[FLAG_BIT]));
endmodule

// File: rtl/watch_timer.sv
module watch_timer
  import wt_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int BASE_EXP = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tickEn,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       irqReq
);
  wtStrobes_t strobes;
  logic       intervalEvt;

  wt_control ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wrEn        (wrEn),
    .wrData      (wrData),
    .intervalEvt (intervalEvt),
    .strobes     (strobes),
    .rdData      (rdData),
    .irqReq      (irqReq)
  );

  wt_datapath #(.CNT_W(CNT_W), .BASE_EXP(BASE_EXP)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tickEn      (tickEn),
    .strobes     (strobes),
    .intervalEvt (intervalEvt)
  );
endmodule

// File: tb/watch_timer_tb.sv
module watch_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tickEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       irqReq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] expRd;
    logic       expIrq;
    string      tag;
  } scoreItem_t;

  scoreItem_t scoreQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  watch_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .irqReq(irqReq)
  );

  // Monitor: pops expected items and compares against the ports.
  initial begin
    forever begin
      scoreItem_t it;
      wait (scoreQ.size() != 0);
      it = scoreQ.pop_front();
      checks++;
      if (rdData !== it.expRd || irqReq !== it.expIrq) begin
        errors++;
        $display("FAIL %s rd=%h exp=%h irq=%b exp=%b",
                 it.tag, rdData, it.expRd, irqReq, it.expIrq);
      end
    end
  end

  // One clock edge with the given inputs; returns just after the next negedge.
  task automatic cycle(input logic we, input logic [7:0] wd, input logic te);
    wrEn = we; wrData = wd; tickEn = te;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 8'h00, 1'b1);
  endtask

  task automatic idles(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 8'h00, 1'b0);
  endtask

  // Driver side of the scoreboard.
  task automatic expect_state(input logic [7:0] rd, input logic irq, input string tag);
    scoreItem_t it;
    it.expRd = rd; it.expIrq = irq; it.tag = tag;
    scoreQ.push_back(it);
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_state(8'h10, 1'b0, "R1 reset value");

    // Period at code 0 from a cleared counter.
    cycle(1'b1, 8'h40, 1'b0);
    ticks(255);
    expect_state(8'h50, 1'b0, "R2 code0 one count early");
    ticks(1);
    expect_state(8'h70, 1'b1, "R2 R7 code0 flag at 256");

    idles(3);
    expect_state(8'h70, 1'b1, "R5 flag sticky");
    cycle(1'b1, 8'h70, 1'b0);
    expect_state(8'h70, 1'b1, "R5 write one keeps flag");
    cycle(1'b1, 8'h30, 1'b0);
    expect_state(8'h30, 1'b0, "R7 irq gated by enable");
    cycle(1'b1, 8'h50, 1'b0);
    expect_state(8'h50, 1'b0, "R5 write zero clears flag");

    // Counter now 256; next event when it reaches 512.
    ticks(255);
    expect_state(8'h50, 1'b0, "R6 before collision");
    cycle(1'b1, 8'h50, 1'b1);
    expect_state(8'h70, 1'b1, "R6 set wins over clear");

    // Code change at count 512: code 1 fires at 1024.
    cycle(1'b1, 8'h51, 1'b0);
    ticks(511);
    expect_state(8'h51, 1'b0, "R8 code change keeps count early");
    ticks(1);
    expect_state(8'h71, 1'b1, "R8 code change keeps count edge");

    // Counter clear strobe, code 1.
    cycle(1'b1, 8'h41, 1'b0);
    ticks(511);
    expect_state(8'h51, 1'b0, "R4 R2 code1 after clear early");
    ticks(1);
    expect_state(8'h71, 1'b1, "R4 R2 code1 period 512");

    // Clear with a simultaneous tick: clear wins.
    cycle(1'b1, 8'h40, 1'b1);
    ticks(255);
    expect_state(8'h50, 1'b0, "R4 clear beats tick early");
    ticks(1);
    expect_state(8'h70, 1'b1, "R4 clear beats tick edge");

    // Reserved bit ignored.
    cycle(1'b1, 8'hD0, 1'b0);
    expect_state(8'h50, 1'b0, "R9 reserved bit reads zero");

    // Time-base enable gating.
    cycle(1'b1, 8'h40, 1'b0);
    ticks(200);
    idles(500);
    ticks(55);
    expect_state(8'h50, 1'b0, "R3 hold while disabled early");
    ticks(1);
    expect_state(8'h70, 1'b1, "R3 hold while disabled edge");

    // Code 3 period 2048 from clear.
    cycle(1'b1, 8'h43, 1'b0);
    ticks(2047);
    expect_state(8'h53, 1'b0, "R2 code3 early");
    ticks(1);
    expect_state(8'h73, 1'b1, "R2 code3 period 2048");

    #2;
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule